// File: doc/BRIEF.md
# Iterative Step Divider

This block divides an unsigned double-width dividend by a single-width divisor. It does the work through a short series of commands, in the way a microcoded datapath would issue them. A setup command loads the upper half of the dividend together with the divisor. It clears the quotient, takes the upper half as the starting remainder and applies one alignment-and-subtract step.

Each later step command supplies a register that holds the lower dividend bits, plus a count of how many of those bits are still to be consumed. The block pulls in one bit per clock cycle, taking the bit at position count-1 as the new remainder LSB. It stops pulling bits when the remainder reaches the divisor or the count runs out, and then applies one more subtract step. It hands back the updated count, and can optionally report through a flag that the count has reached zero.

The controlling sequencer repeats step commands until the returned count is zero. It then reads the quotient and the remainder from their own output ports. Step commands that arrive with a zero count change nothing, so a loop that issues more steps than it needs gives the same result.

Top module: `div_step_unit`

## Requirements
- R1: After reset, quotient, remainder and returned count read 0, the zero-count flag reads 0, `cmd_ready_o` is 1 and `done_o` is 0.
- R2: A setup command with a nonzero divisor completes in the cycle after it is accepted. It loads quotient 0, remainder = `opa_i` and divisor = `opb_i`, and then applies one subtract step. If divisor ≤ remainder, the divisor is shifted left until its top set bit lines up with the remainder's top set bit. If that overshoots the remainder, both the divisor and the quotient weight move back by one bit. The quotient weight is then added to the quotient and the shifted divisor is subtracted from the remainder. For example, 200 / 7 gives quotient 16 and remainder 88.
- R3: A setup command with `opb_i` = 0 is a divide-by-zero error. So is a step command with a nonzero count while the held divisor is 0. Either one raises `err_o` together with `done_o` and changes neither quotient, remainder, returned count nor flag.
- R4: A step command with count 0 completes in the cycle after acceptance. It leaves quotient and remainder unchanged and returns count 0.
- R5: A step command with a nonzero count spends one cycle per pulled-in bit. In each such cycle, while remainder < divisor and count ≠ 0, the remainder shifts left with bit (count-1) of the source as its new LSB, the quotient shifts left by one and the count decrements. The block then spends one further cycle on a subtract step, done only when divisor ≤ remainder, and returns the remaining count on `cnt_o`. `cnt_o` changes only when `done_o` is raised.
- R6: When a step completes with `zf_en_i` = 1 latched at acceptance, `zf_o` becomes 1 if the returned count is 0 and 0 otherwise. With `zf_en_i` = 0, and on any setup command, `zf_o` keeps its value.
- R7: `cmd_ready_o` is 0 while a step is in progress, and `done_o` is a one-cycle pulse that is raised only while `cmd_ready_o` is 1.
- R8: For any high part smaller than the divisor, the sequence is setup(high, divisor) followed by steps with count = W on the low part, each step reusing the returned count, until the count is 0. It leaves `quo_o` = {high,low} / divisor and `rem_o` = {high,low} mod divisor. This holds even when the divisor's top bit is set, because the remainder is kept one bit wider internally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid_i | input | 1 | Command present |
| cmd_ready_o | output | 1 | Block can accept a command |
| cmd_setup_i | input | 1 | 1 = setup command, 0 = step command |
| opa_i | input | W | Setup: dividend high part; step: register holding low dividend bits |
| opb_i | input | W | Setup: divisor (ignored by step) |
| cnt_i | input | CW | Step: count of bits still to bring in |
| zf_en_i | input | 1 | Step: enable update of the zero-count flag |
| done_o | output | 1 | Command completed (one-cycle pulse) |
| err_o | output | 1 | Divide by zero, valid with done_o |
| cnt_o | output | CW | Count returned by the last completed step |
| zf_o | output | 1 | Zero-count flag |
| quo_o | output | W | Quotient |
| rem_o | output | W | Remainder |

## Verification
The bench builds the divider with W = 8. At that width every divisor from 1 to 255 can be swept, each paired with a low, a middle and a maximal high part and several low parts. This covers divisors with the top bit set, where the widened remainder matters, as well as divisors of 1, where one step retires many quotient bits. Directed cases pin the single setup subtraction with its back-off, the per-bit latency of a step, zero-count steps, both divide-by-zero paths and the flag mask.

// File: rtl/div_step_unit.sv
module div_step_unit #(
  parameter int W  = 64,
  parameter int CW = $clog2(W + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid_i,
  output logic          cmd_ready_o,
  input  logic          cmd_setup_i,
  input  logic [W-1:0]  opa_i,
  input  logic [W-1:0]  opb_i,
  input  logic [CW-1:0] cnt_i,
  input  logic          zf_en_i,
  output logic          done_o,
  output logic          err_o,
  output logic [CW-1:0] cnt_o,
  output logic          zf_o,
  output logic [W-1:0]  quo_o,
  output logic [W-1:0]  rem_o
);
  localparam int RW = W + 1;
  localparam int SW = $clog2(RW);

  typedef enum logic {S_IDLE, S_RUN} st_t;

  st_t           st;
  logic [W-1:0]  quo, dvs, src;
  logic [RW-1:0] rem;
  logic [CW-1:0] cnt, cnt_q;
  logic          zf_q, zf_en_q, done_q, err_q;

  function automatic logic [SW-1:0] msb_of(input logic [RW-1:0] v);
    msb_of = '0;
    for (int i = 0; i < RW; i++)
      if (v[i]) msb_of = SW'(i);
  endfunction

  logic [RW-1:0] sx_rem, sx_dvs, dsh, qb, nr;
  logic [W-1:0]  sx_quo, nq;
  logic [SW-1:0] sh;
  logic          idle;

  assign idle   = (st == S_IDLE);
  assign sx_rem = idle ? {1'b0, opa_i} : rem;
  assign sx_dvs = idle ? {1'b0, opb_i} : {1'b0, dvs};
  assign sx_quo = idle ? '0 : quo;

  always_comb begin
    sh  = msb_of(sx_rem) - msb_of(sx_dvs);
    dsh = '0;
    qb  = '0;
    nq  = sx_quo;
    nr  = sx_rem;
    if (sx_dvs != '0 && sx_dvs <= sx_rem) begin
      dsh = sx_dvs << sh;
      qb  = RW'(1) << sh;
      if (dsh > sx_rem) begin
        dsh = dsh >> 1;
        qb  = qb >> 1;
      end
      nq = sx_quo + qb[W-1:0];
      nr = sx_rem - dsh;
    end
  end

  logic [W-1:0] src_sh;
  logic         need_shift;
  assign src_sh     = src >> (cnt - CW'(1));
  assign need_shift = (rem < {1'b0, dvs}) && (cnt != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      quo     <= '0;
      rem     <= '0;
      dvs     <= '0;
      src     <= '0;
      cnt     <= '0;
      cnt_q   <= '0;
      zf_q    <= 1'b0;
      zf_en_q <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      case (st)
        S_IDLE: if (cmd_valid_i) begin
          if (cmd_setup_i) begin
            done_q <= 1'b1;
            if (opb_i == '0) err_q <= 1'b1;
            else begin
              quo <= nq;
              rem <= nr;
              dvs <= opb_i;
            end
          end else if (cnt_i == '0) begin
            done_q <= 1'b1;
            cnt_q  <= '0;
            if (zf_en_i) zf_q <= 1'b1;
          end else if (dvs == '0) begin
            done_q <= 1'b1;
            err_q  <= 1'b1;
          end else begin
            src     <= opa_i;
            cnt     <= cnt_i;
            zf_en_q <= zf_en_i;
            st      <= S_RUN;
          end
        end
        S_RUN: begin
          if (need_shift) begin
            rem <= {rem[RW-2:0], src_sh[0]};
            quo <= quo << 1;
            cnt <= cnt - CW'(1);
          end else begin
            quo    <= nq;
            rem    <= nr;
            cnt_q  <= cnt;
            if (zf_en_q) zf_q <= (cnt == '0);
            done_q <= 1'b1;
            st     <= S_IDLE;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign cmd_ready_o = idle;
  assign done_o      = done_q;
  assign err_o       = err_q;
  assign cnt_o       = cnt_q;
  assign zf_o        = zf_q;
  assign quo_o       = quo;
  assign rem_o       = rem[W-1:0];
endmodule

// File: rtl/div_step_unit_chk.sv
module div_step_unit_chk #(
  parameter int W  = 64,
  parameter int CW = $clog2(W + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cmd_valid_i,
  input logic          cmd_ready_o,
  input logic          cmd_setup_i,
  input logic [W-1:0]  opa_i,
  input logic [W-1:0]  opb_i,
  input logic [CW-1:0] cnt_i,
  input logic          done_o,
  input logic          err_o,
  input logic [CW-1:0] cnt_o,
  input logic          zf_o,
  input logic [W-1:0]  quo_o,
  input logic [W-1:0]  rem_o
);
  logic acc;
  assign acc = cmd_valid_i && cmd_ready_o;

  assert_done_when_ready_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> cmd_ready_o);

  assert_err_with_done_R3: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> done_o);

  assert_err_keeps_state_R3: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> ($stable(quo_o) && $stable(rem_o) && $stable(cnt_o) && $stable(zf_o)));

  assert_setup_one_cycle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(acc && cmd_setup_i && opb_i != '0))
      |-> (done_o && !err_o && rem_o <= $past(opa_i)));

  assert_zero_count_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(acc && !cmd_setup_i && cnt_i == '0))
      |-> (done_o && cnt_o == '0 && $stable(quo_o) && $stable(rem_o)));

  assert_count_on_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> $stable(cnt_o));

  assert_setup_keeps_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(acc && cmd_setup_i)) |-> $stable(zf_o));
endmodule

bind div_step_unit div_step_unit_chk #(.W(W), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid_i(cmd_valid_i), .cmd_ready_o(cmd_ready_o),
  .cmd_setup_i(cmd_setup_i), .opa_i(opa_i), .opb_i(opb_i), .cnt_i(cnt_i),
  .done_o(done_o), .err_o(err_o), .cnt_o(cnt_o), .zf_o(zf_o),
  .quo_o(quo_o), .rem_o(rem_o)
);

// File: tb/div_step_unit_bench.sv
module div_step_unit_bench;
  localparam int W = 8;
  localparam int CW = $clog2(W + 1);
  localparam int CLK_PERIOD = 10;
  localparam int MAX_CYC = 190000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid_i = 1'b0, cmd_setup_i = 1'b0, zf_en_i = 1'b0;
  logic [W-1:0] opa_i = '0, opb_i = '0;
  logic [CW-1:0] cnt_i = '0;
  logic cmd_ready_o, done_o, err_o, zf_o;
  logic [CW-1:0] cnt_o;
  logic [W-1:0] quo_o, rem_o;

  int total = 0, bad = 0, cyc = 0, lat = 0;
  logic ready_mid;

  div_step_unit #(.W(W), .CW(CW)) u_div_step_unit (
    .clk(clk), .rst_n(rst_n), .cmd_valid_i(cmd_valid_i), .cmd_ready_o(cmd_ready_o),
    .cmd_setup_i(cmd_setup_i), .opa_i(opa_i), .opb_i(opb_i), .cnt_i(cnt_i),
    .zf_en_i(zf_en_i), .done_o(done_o), .err_o(err_o), .cnt_o(cnt_o),
    .zf_o(zf_o), .quo_o(quo_o), .rem_o(rem_o)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > MAX_CYC) begin
      total++; bad++;
      $display("FAIL watchdog: run hung, actual cycles=%0d expected below %0d", cyc, MAX_CYC);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input string req, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic issue(input logic setup, input logic [W-1:0] a, input logic [W-1:0] b,
                       input logic [CW-1:0] c, input logic en);
    @(negedge clk);
    while (!cmd_ready_o) @(negedge clk);
    cmd_setup_i = setup; opa_i = a; opb_i = b; cnt_i = c; zf_en_i = en;
    cmd_valid_i = 1'b1;
    @(negedge clk);
    cmd_valid_i = 1'b0;
    lat = 0;
    ready_mid = 1'b1;
    while (!done_o) begin
      @(negedge clk);
      lat++;
      if (lat == 1) ready_mid = cmd_ready_o;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 quo", quo_o, 0); chk("R1 rem", rem_o, 0); chk("R1 cnt", cnt_o, 0);
    chk("R1 zf", zf_o, 0); chk("R1 ready", cmd_ready_o, 1); chk("R1 done", done_o, 0);
    rst_n = 1'b1;

    // R3 step with nonzero count while held divisor is zero
    issue(1'b0, 8'hFF, 8'h00, 4'd3, 1'b1);
    chk("R3 step err", err_o, 1); chk("R3 step quo", quo_o, 0);
    chk("R3 step rem", rem_o, 0); chk("R3 step cnt", cnt_o, 0); chk("R3 step zf", zf_o, 0);

    // R2 setup: single subtraction with back-off
    issue(1'b1, 8'd200, 8'd7, 4'd0, 1'b0);
    chk("R2 lat", lat, 0); chk("R2 err", err_o, 0);
    chk("R2 quo 200/7", quo_o, 16); chk("R2 rem 200/7", rem_o, 88);
    issue(1'b1, 8'd14, 8'd7, 4'd0, 1'b0);
    chk("R2 quo 14/7", quo_o, 2); chk("R2 rem 14/7", rem_o, 0);
    issue(1'b1, 8'd3, 8'd7, 4'd0, 1'b0);
    chk("R2 quo 3/7", quo_o, 0); chk("R2 rem 3/7", rem_o, 3);

    // R3 setup with zero divisor
    issue(1'b1, 8'd9, 8'd0, 4'd0, 1'b1);
    chk("R3 setup err", err_o, 1); chk("R3 setup quo", quo_o, 0); chk("R3 setup rem", rem_o, 3);

    // R5 step: three shifted bits then one subtract, flag cleared (R6)
    issue(1'b1, 8'd0, 8'd5, 4'd0, 1'b0);
    issue(1'b0, 8'hE0, 8'd0, 4'd8, 1'b1);
    chk("R5 lat", lat, 4); chk("R7 busy ready", ready_mid, 0);
    chk("R5 cnt", cnt_o, 5); chk("R5 quo", quo_o, 1); chk("R5 rem", rem_o, 2);
    chk("R6 zf cleared", zf_o, 0);

    // R4 zero-count step, R6 flag set
    issue(1'b0, 8'hFF, 8'd0, 4'd0, 1'b1);
    chk("R4 lat", lat, 0); chk("R4 cnt", cnt_o, 0);
    chk("R4 quo", quo_o, 1); chk("R4 rem", rem_o, 2); chk("R6 zf set", zf_o, 1);

    // R6 mask off: flag keeps 1 although count becomes 0 after a shift
    issue(1'b1, 8'd0, 8'd5, 4'd0, 1'b0);
    issue(1'b0, 8'hFF, 8'd0, 4'd1, 1'b0);
    chk("R5 one-bit cnt", cnt_o, 0); chk("R5 one-bit rem", rem_o, 1);
    chk("R5 one-bit quo", quo_o, 0); chk("R6 masked zf", zf_o, 1);

    // R8 sweep over all divisors
    for (int d = 1; d < 256; d++) begin
      for (int hs = 0; hs < 3; hs++) begin
        for (int ls = 0; ls < 5; ls++) begin
          int hi, lo, c, n;
          longint num;
          hi = (hs == 0) ? 0 : (hs == 1) ? d - 1 : d / 2;
          lo = (ls == 0) ? 0 : (ls == 1) ? 8'h5A : (ls == 2) ? 8'hA7 : (ls == 3) ? 8'hFF : d;
          issue(1'b1, W'(hi), W'(d), 4'd0, 1'b0);
          c = W; n = 0;
          while (c != 0 && n < W + 2) begin
            issue(1'b0, W'(lo), 8'd0, CW'(c), 1'b1);
            c = int'(cnt_o); n++;
          end
          num = longint'(hi) * 256 + longint'(lo);
          total++;
          if (quo_o != W'(num / d) || rem_o != W'(num % d) || c != 0) begin
            bad++;
            $display("FAIL R8 %0d/%0d: actual q=%0d r=%0d cnt=%0d expected q=%0d r=%0d cnt=0",
                     num, d, quo_o, rem_o, c, num / d, num % d);
          end
        end
      end
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule